// File: doc/BRIEF.md
# Memory Region Decoder with Configuration Register

The block takes a 21-bit processor word address and decides which memory device the access targets. The candidates are DRAM, a slow and a fast 20-bit SRAM window, and a slow and a fast 8-bit ROM window. It raises exactly one select line for the target, or raises a decode-error flag when the address lies in a hole of the map. For ROM accesses it builds the byte address from the low address bits and a two-bit page number held in configuration. It also reports how many clock cycles the access needs. That count is derived from the device speed grade, a process/temperature trim code, a supply-voltage flag and a fixed bus overhead.

A 20-bit main configuration register holds the settings. Software can read it, modify it and write it back. Its reset value selects ROM page 3, slow grades, 5 V operation, the slowest trim, large DRAM and refresh-on-access mode. The decode and wait outputs are combinational from the address and the registered configuration. A configuration write therefore affects them from the clock edge that captures it.

Top module: `mem_region_dec`

## Requirements
- R1: The configuration register resets to 0xC0000. When cfg_we_i is high at a rising edge, all 20 bits of cfg_wdata_i are stored and appear on cfg_rdata_o. When cfg_we_i is low, the register keeps its value.
- R2: With configuration bit 7 clear, addresses 0x000000–0x0FFFFF select DRAM (sel_o bit 0). With bit 7 set (small DRAM), only 0x000000–0x03FFFF select DRAM, and 0x040000–0x0FFFFF are decode errors.
- R3: 0x100000–0x103FFF selects slow SRAM (sel_o bit 1) and 0x140000–0x143FFF selects fast SRAM (sel_o bit 2). 0x104000–0x13FFFF and 0x144000–0x17FFFF are decode errors.
- R4: 0x180000–0x1BFFFF selects slow ROM (sel_o bit 3) and 0x1C0000–0x1FFFFF selects fast ROM (sel_o bit 4).
- R5: For every address, exactly one of the five sel_o bits or dec_err_o is high. While dec_err_o is high, wait_o is 0.
- R6: rom_addr_o equals {configuration bits 19:18, addr_i[17:0]}, giving four 256K-byte pages.
- R7: Device access times are as follows. DRAM is DRAM_NS (80 ns). Slow SRAM is 25 ns, or 12 ns when configuration bit 16 is set. Fast SRAM is always 12 ns. Slow ROM is 250 ns, or 150 ns when configuration bit 14 is set. Fast ROM is always 150 ns.
- R8: Trim code bits 9:8 scale the access time by 140%, 120%, 100% and 80% for codes 00, 01, 10 and 11. In picoseconds, t = base_ns × percent × 10. When bit 10 (3 V) is set, t becomes floor(t × 100 / 155). The wait count is ceil((t + 10000) / CLK_PS).
- R9: irq_en_o equals configuration bits 2:0 (video, network, analog). refresh_only_o is high when configuration bit 6 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 21 | Processor word address |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_wdata_i | input | 20 | Configuration write data |
| cfg_rdata_o | output | 20 | Configuration register contents |
| sel_o | output | 5 | One-hot region select: DRAM, slow SRAM, fast SRAM, slow ROM, fast ROM |
| dec_err_o | output | 1 | Address maps to no device |
| rom_addr_o | output | 20 | Paged ROM byte address |
| wait_o | output | 5 | Access duration in clock cycles |
| irq_en_o | output | 3 | Interrupt enables |
| refresh_only_o | output | 1 | Refresh-on-access mode |

## Verification
The hardest cases to reach are those where the configuration changes what an address means. Examples are a DRAM address that becomes a decode error once the small-DRAM bit is set, or a wait count that moves with the speed, trim and voltage fields. Each vector therefore writes a full configuration word first and then applies the address. The cases include the 0x03FFFF/0x040000 boundary under the small-DRAM setting, the holes just past each SRAM window, and 3 V combined with the extreme trim codes. Expected wait counts come from the bench's own arithmetic.

// File: rtl/mem_region_pkg.sv
package mem_region_pkg;
  localparam int unsigned N_REGION = 5;
  localparam int unsigned N_BASE   = 5;

  // sel bit positions
  localparam int unsigned RG_DRAM      = 0;
  localparam int unsigned RG_SRAM_SLOW = 1;
  localparam int unsigned RG_SRAM_FAST = 2;
  localparam int unsigned RG_ROM_SLOW  = 3;
  localparam int unsigned RG_ROM_FAST  = 4;

  // configuration fields
  localparam int unsigned CF_PAGE_LO = 18;
  localparam int unsigned CF_RAM_FST = 16;
  localparam int unsigned CF_ROM_FST = 14;
  localparam int unsigned CF_LOW_V   = 10;
  localparam int unsigned CF_TRIM_LO = 8;
  localparam int unsigned CF_SMALL   = 7;
  localparam int unsigned CF_NORMREF = 6;

  typedef enum logic [2:0] {
    BT_DRAM, BT_SRAM25, BT_SRAM12, BT_ROM250, BT_ROM150
  } base_e;

  function automatic int unsigned base_ns(int unsigned b, int unsigned dram_ns);
    case (b)
      0:       return dram_ns;
      1:       return 25;
      2:       return 12;
      3:       return 250;
      default: return 150;
    endcase
  endfunction

  function automatic int unsigned wait_cycles(int unsigned bns, int unsigned trim,
                                              int unsigned low_v, int unsigned clk_ps,
                                              int unsigned ovh_ps);
    int unsigned pct;
    int unsigned t;
    case (trim)
      0:       pct = 140;
      1:       pct = 120;
      2:       pct = 100;
      default: pct = 80;
    endcase
    t = bns * pct * 10;
    if (low_v != 0) t = (t * 100) / 155;
    return (t + ovh_ps + clk_ps - 1) / clk_ps;
  endfunction
endpackage

// File: rtl/mem_cfg_reg.sv
module mem_cfg_reg #(
  parameter int unsigned       CFG_W     = 20,
  parameter logic [CFG_W-1:0]  RESET_VAL = 20'hC0000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RESET_VAL;
    else if (we_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/mem_addr_decode.sv
module mem_addr_decode
  import mem_region_pkg::*;
#(
  parameter int unsigned ADDR_W = 21
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                small_dram_i,
  output logic [N_REGION-1:0] sel_o,
  output logic                err_o
);
  localparam int unsigned TOP = ADDR_W - 1;

  logic unused_addr;
  assign unused_addr = ^addr_i[13:0];

  always_comb begin
    sel_o = '0;
    if (!addr_i[TOP]) begin
      // small DRAM keeps only the lowest 256K words
      if (!small_dram_i || addr_i[TOP-1:TOP-2] == 2'b00) sel_o[RG_DRAM] = 1'b1;
    end else if (addr_i[TOP-1]) begin
      if (addr_i[TOP-2]) sel_o[RG_ROM_FAST] = 1'b1;
      else               sel_o[RG_ROM_SLOW] = 1'b1;
    end else if (addr_i[TOP-3:14] == '0) begin
      if (addr_i[TOP-2]) sel_o[RG_SRAM_FAST] = 1'b1;
      else               sel_o[RG_SRAM_SLOW] = 1'b1;
    end
  end

  assign err_o = (sel_o == '0);
endmodule

// File: rtl/mem_wait_table.sv
module mem_wait_table
  import mem_region_pkg::*;
#(
  parameter int unsigned DRAM_NS = 80,
  parameter int unsigned CLK_PS  = 20000,
  parameter int unsigned OVH_PS  = 10000,
  parameter int unsigned WAIT_W  = 5
) (
  input  logic              valid_i,
  input  base_e             base_i,
  input  logic [1:0]        trim_i,
  input  logic              low_v_i,
  output logic [WAIT_W-1:0] wait_o
);
  logic [WAIT_W-1:0] tab [N_BASE][2][4];

  for (genvar b = 0; b < N_BASE; b++) begin : g_base
    for (genvar v = 0; v < 2; v++) begin : g_volt
      for (genvar t = 0; t < 4; t++) begin : g_trim
        localparam int unsigned W =
          wait_cycles(base_ns(b, DRAM_NS), t, v, CLK_PS, OVH_PS);
        assign tab[b][v][t] = WAIT_W'(W);
      end
    end
  end

  always_comb begin
    wait_o = '0;
    if (valid_i && int'(base_i) < N_BASE) wait_o = tab[base_i][low_v_i][trim_i];
  end
endmodule

// File: rtl/mem_region_dec.sv
module mem_region_dec
  import mem_region_pkg::*;
#(
  parameter int unsigned ADDR_W  = 21,
  parameter int unsigned CFG_W   = 20,
  parameter int unsigned WAIT_W  = 5,
  parameter int unsigned DRAM_NS = 80,
  parameter int unsigned CLK_PS  = 20000,
  parameter int unsigned OVH_PS  = 10000,
  parameter int unsigned IRQ_W   = 3,
  parameter int unsigned PAGE_W  = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                cfg_we_i,
  input  logic [CFG_W-1:0]    cfg_wdata_i,
  output logic [CFG_W-1:0]    cfg_rdata_o,
  output logic [N_REGION-1:0] sel_o,
  output logic                dec_err_o,
  output logic [CFG_W-1:0]    rom_addr_o,
  output logic [WAIT_W-1:0]   wait_o,
  output logic [IRQ_W-1:0]    irq_en_o,
  output logic                refresh_only_o
);
  localparam int unsigned ROM_OFS_W = CFG_W - PAGE_W;

  logic [CFG_W-1:0] cfg;
  base_e            base;

  mem_cfg_reg #(.CFG_W(CFG_W), .RESET_VAL(CFG_W'(20'hC0000))) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .q_o     (cfg)
  );

  mem_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i       (addr_i),
    .small_dram_i (cfg[CF_SMALL]),
    .sel_o        (sel_o),
    .err_o        (dec_err_o)
  );

  always_comb begin
    base = BT_DRAM;
    unique case (1'b1)
      sel_o[RG_SRAM_SLOW]: base = cfg[CF_RAM_FST] ? BT_SRAM12 : BT_SRAM25;
      sel_o[RG_SRAM_FAST]: base = BT_SRAM12;
      sel_o[RG_ROM_SLOW]:  base = cfg[CF_ROM_FST] ? BT_ROM150 : BT_ROM250;
      sel_o[RG_ROM_FAST]:  base = BT_ROM150;
      default:             base = BT_DRAM;
    endcase
  end

  mem_wait_table #(
    .DRAM_NS(DRAM_NS), .CLK_PS(CLK_PS), .OVH_PS(OVH_PS), .WAIT_W(WAIT_W)
  ) u_wait (
    .valid_i (!dec_err_o),
    .base_i  (base),
    .trim_i  (cfg[CF_TRIM_LO +: 2]),
    .low_v_i (cfg[CF_LOW_V]),
    .wait_o  (wait_o)
  );

  assign cfg_rdata_o    = cfg;
  assign rom_addr_o     = {cfg[CF_PAGE_LO +: PAGE_W], addr_i[ROM_OFS_W-1:0]};
  assign irq_en_o       = cfg[IRQ_W-1:0];
  assign refresh_only_o = !cfg[CF_NORMREF];
endmodule

// File: rtl/mem_region_dec_chk.sv
module mem_region_dec_chk #(
  parameter int unsigned ADDR_W = 21,
  parameter int unsigned CFG_W  = 20,
  parameter int unsigned WAIT_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              cfg_we_i,
  input logic [CFG_W-1:0]  cfg_wdata_i,
  input logic [CFG_W-1:0]  cfg_rdata_o,
  input logic [4:0]        sel_o,
  input logic              dec_err_o,
  input logic [CFG_W-1:0]  rom_addr_o,
  input logic [WAIT_W-1:0] wait_o,
  input logic [2:0]        irq_en_o
);
  p_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> cfg_rdata_o == $past(cfg_wdata_i));
  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(cfg_rdata_o));
  p_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({sel_o, dec_err_o}) == 1);
  p_nowait_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_err_o |-> wait_o == '0);
  p_waitnz_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_err_o |-> wait_o != '0);
  p_dram_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o[0] |-> !addr_i[ADDR_W-1]);
  p_rom_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o[3] || sel_o[4]) |-> addr_i[ADDR_W-1 -: 2] == 2'b11);
  p_page_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_addr_o[CFG_W-1 -: 2] == cfg_rdata_o[CFG_W-1 -: 2]);
  p_irq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_en_o == cfg_rdata_o[2:0]);
endmodule

bind mem_region_dec mem_region_dec_chk #(.ADDR_W(ADDR_W), .CFG_W(CFG_W), .WAIT_W(WAIT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .cfg_we_i    (cfg_we_i),
  .cfg_wdata_i (cfg_wdata_i),
  .cfg_rdata_o (cfg_rdata_o),
  .sel_o       (sel_o),
  .dec_err_o   (dec_err_o),
  .rom_addr_o  (rom_addr_o),
  .wait_o      (wait_o),
  .irq_en_o    (irq_en_o)
);

// File: tb/mem_region_dec_test.sv
module mem_region_dec_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [20:0] addr = '0;
  logic        we = 1'b0;
  logic [19:0] wdata = '0;
  logic [19:0] rdata;
  logic [4:0]  sel;
  logic        err;
  logic [19:0] rom_addr;
  logic [4:0]  wt;
  logic [2:0]  irq;
  logic        refr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  mem_region_dec uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .cfg_we_i(we),
    .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .sel_o(sel), .dec_err_o(err),
    .rom_addr_o(rom_addr), .wait_o(wt), .irq_en_o(irq), .refresh_only_o(refr)
  );

  // {cfg, addr, sel, err}
  localparam int NV = 16;
  localparam logic [46:0] VEC [NV] = '{
    {20'hC0000, 21'h000000, 5'b00001, 1'b0},  // R2
    {20'hC0000, 21'h0FFFFF, 5'b00001, 1'b0},  // R2
    {20'hC0080, 21'h03FFFF, 5'b00001, 1'b0},  // R2 small
    {20'hC0080, 21'h040000, 5'b00000, 1'b1},  // R2 small hole
    {20'hC0000, 21'h100000, 5'b00010, 1'b0},  // R3
    {20'hD0000, 21'h103FFF, 5'b00010, 1'b0},  // R3 fast grade
    {20'hC0000, 21'h104000, 5'b00000, 1'b1},  // R3 hole
    {20'hC0200, 21'h140000, 5'b00100, 1'b0},  // R3
    {20'hC0000, 21'h144000, 5'b00000, 1'b1},  // R3 hole
    {20'hC4000, 21'h180000, 5'b01000, 1'b0},  // R4 fast grade
    {20'h00000, 21'h1BFFFF, 5'b01000, 1'b0},  // R4 page 0
    {20'h40700, 21'h1C0000, 5'b10000, 1'b0},  // R4 3V fast trim
    {20'h80100, 21'h1FFFFF, 5'b10000, 1'b0},  // R4
    {20'hC0400, 21'h100000, 5'b00010, 1'b0},  // R8 3V slow trim
    {20'hC0300, 21'h0ABCDE, 5'b00001, 1'b0},  // R8 dram fast trim
    {20'h00000, 21'h17FFFF, 5'b00000, 1'b1}   // R5 hole
  };

  function automatic int exp_wait(logic [19:0] c, logic [4:0] s);
    int b, pct, t;
    if (s == 0) return 0;
    if (s[0])      b = 80;
    else if (s[1]) b = c[16] ? 12 : 25;
    else if (s[2]) b = 12;
    else if (s[3]) b = c[14] ? 150 : 250;
    else           b = 150;
    case (c[9:8])
      2'b00: pct = 140;
      2'b01: pct = 120;
      2'b10: pct = 100;
      default: pct = 80;
    endcase
    t = b * pct * 10;
    if (c[10]) t = t * 100 / 155;
    return (t + 10000 + 19999) / 20000;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(logic [19:0] v);
    @(negedge clk); we = 1'b1; wdata = v;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #5;
    chk("R1 reset cfg", int'(rdata), 'hC0000);
    chk("R9 reset irq", int'(irq), 0);
    chk("R9 reset refresh", int'(refr), 1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [19:0] c;
      logic [20:0] a;
      logic [4:0]  s;
      logic        e;
      {c, a, s, e} = VEC[i];
      wr_cfg(c);
      addr = a;
      #5;
      chk("R1 readback", int'(rdata), int'(c));
      chk("R2/R3/R4 sel", int'(sel), int'(s));
      chk("R5 err", int'(err), int'(e));
      chk("R6 rom_addr", int'(rom_addr), int'({c[19:18], a[17:0]}));
      chk("R7/R8 wait", int'(wt), exp_wait(c, s));
    end

    // R9 fields
    wr_cfg(20'hC0045);
    #5;
    chk("R9 irq", int'(irq), 5);
    chk("R9 refresh normal", int'(refr), 0);

    // R1 ignored write while enable low
    @(negedge clk); wdata = 20'h12345;
    @(negedge clk); #5;
    chk("R1 hold", int'(rdata), 'hC0045);

    // R1 all bits writable
    wr_cfg(20'hFFFFF);
    #5;
    chk("R1 all ones", int'(rdata), 'hFFFFF);

    // R8 extremes: slow ROM 250ns, 5V, trim 00 -> 18 cycles
    wr_cfg(20'hC0000);
    addr = 21'h1A0000; #5;
    chk("R8 max wait", int'(wt), 18);

    // R1 reset mid-run restores value
    wr_cfg(20'h00007);
    @(negedge clk); rst_n = 1'b0;
    #5;
    chk("R1 async reset", int'(rdata), 'hC0000);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #5;
    chk("R1 after reset", int'(rdata), 'hC0000);

    finish_run();
  end
endmodule